// File: doc/BRIEF.md
# Width-Adapting Bus Slave Port

This block sits between a shared-bus master and a single slave in a Wishbone-style interconnect. It decides from the upper master address bits whether the access targets this slave. When it does, the block forwards the cycle, strobe and write-enable signals and a slice of the address to the slave. When it does not, every slave-side output is held at zero.

The slave may have a wider or narrower data bus than the master, and it may have fewer byte-select lines than it has byte lanes. On writes, the block replicates or truncates the master data to fit the slave. It converts the master byte enables into one enable per slave lane. When the slave is wider, the lane group is picked with low address bits. It then ORs consecutive lane enables together to match the slave's select width. On reads, it folds the enabled slave lanes back onto the master lanes.

The acknowledge comes from the slave, or is asserted on every selected access when the slave has no acknowledge output. The block is purely combinational and all widths are compile-time parameters.

Top module: `wb_width_port`

## Requirements
- R1: The slave is selected exactly when `m_adr[AW-1:DEC_LSB]` equals `BASE`.
- R2: While not selected, `s_adr`, `s_dat_w` and `s_sel` are all zero, and `s_cyc`, `s_stb` and `s_we` are low.
- R3: While selected, `s_cyc`, `s_stb` and `s_we` equal `m_cyc`, `m_stb` and `m_we`.
- R4: While selected, `s_adr` equals `m_adr[DEC_LSB-1:SEL_BASE]`.
- R5: While selected, bit i of `s_dat_w` equals bit (i mod MDW) of `m_dat_w`. A wider slave therefore sees the master word repeated, and a narrower slave sees its low bits.
- R6: With MB = MDW/8 master enables and SL = SDW/8 slave lanes, SL > MB, and g = `m_adr[log2(MB)+log2(SL/MB)-1 : log2(MB)]`, lane (k*MB + b) is enabled exactly when k = g and `m_sel[b]` is set.
- R7: When SL <= MB, lane i is enabled exactly when `m_sel[i]` is set.
- R8: While selected, `s_sel[j]` is the OR of lane enables j*G through j*G+G-1, with G = SL/SSW. A slave with SSW = SL takes the lane enables directly, and SSW = 1 takes the OR of all lanes.
- R9: While selected, byte b of `m_dat_r` is the OR of every enabled slave lane i with i mod MB = b, and is zero if no such lane is enabled. While not selected, `m_dat_r` is zero.
- R10: `m_ack` equals selected AND `s_ack` when `HAS_ACK` is 1, and equals selected when `HAS_ACK` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_adr | input | AW | Master byte address |
| m_dat_w | input | MDW | Master write data |
| m_sel | input | MDW/8 | Master byte enables |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_dat_r | output | MDW | Read data returned to the master |
| m_ack | output | 1 | Acknowledge returned to the master |
| s_adr | output | DEC_LSB-SEL_BASE | Slave address |
| s_dat_w | output | SDW | Slave write data |
| s_sel | output | SSW | Slave byte selects |
| s_cyc | output | 1 | Slave cycle |
| s_stb | output | 1 | Slave strobe |
| s_we | output | 1 | Slave write enable |
| s_dat_r | input | SDW | Slave read data |
| s_ack | input | 1 | Slave acknowledge (ignored when HAS_ACK is 0) |

## Verification
The block holds no state, so any wrong lane-group index or select grouping shows up in the same cycle. It appears as a byte-select pattern on the wrong slave lanes, or as read bytes folded onto the wrong master lane. A stuck decode shows up as slave strobes or a master acknowledge during accesses that belong to another slave. Three instances with wider, equal and narrower slave buses are driven together. Every output is compared each cycle, so a fault in any width branch appears on the first access that exercises it.

// File: rtl/wb_width_port.sv
module wb_width_port #(
  parameter int AW       = 16,
  parameter int MDW      = 32,
  parameter int SDW      = 64,
  parameter int SSW      = 8,
  parameter int DEC_LSB  = 12,
  parameter int SEL_BASE = 3,
  parameter int BASE     = 3,
  parameter bit HAS_ACK  = 1'b1
) (
  input  logic [AW-1:0]               m_adr,
  input  logic [MDW-1:0]              m_dat_w,
  input  logic [MDW/8-1:0]            m_sel,
  input  logic                        m_cyc,
  input  logic                        m_stb,
  input  logic                        m_we,
  output logic [MDW-1:0]              m_dat_r,
  output logic                        m_ack,
  output logic [DEC_LSB-SEL_BASE-1:0] s_adr,
  output logic [SDW-1:0]              s_dat_w,
  output logic [SSW-1:0]              s_sel,
  output logic                        s_cyc,
  output logic                        s_stb,
  output logic                        s_we,
  input  logic [SDW-1:0]              s_dat_r,
  input  logic                        s_ack
);
  localparam int MB  = MDW / 8;
  localparam int SL  = SDW / 8;
  localparam int MBL = (MB > 1) ? $clog2(MB) : 0;
  localparam int G   = SL / SSW;
  localparam int BW  = AW - DEC_LSB;

  logic          hit;
  logic [SL-1:0] lane_en;
  logic [SSW-1:0] grp_sel;
  logic [SDW-1:0] wdat;
  logic [MDW-1:0] rd;
  logic          ack_src;
  logic          unused_in;

  assign unused_in = ^{m_adr, m_sel, m_dat_w, s_ack};

  assign hit = (m_adr[AW-1:DEC_LSB] == BW'(BASE));

  assign s_cyc = hit & m_cyc;
  assign s_stb = hit & m_stb;
  assign s_we  = hit & m_we;
  assign s_adr = hit ? m_adr[DEC_LSB-1:SEL_BASE] : '0;

  generate
    if (SL > MB) begin : g_wide_lanes
      localparam int K = $clog2(SL / MB);
      logic [K-1:0] grp;
      assign grp = m_adr[MBL+K-1:MBL];
      for (genvar k = 0; k < SL / MB; k++) begin : g_grp
        assign lane_en[k*MB +: MB] = (grp == K'(k)) ? m_sel : '0;
      end
    end else begin : g_direct_lanes
      assign lane_en = m_sel[SL-1:0];
    end

    for (genvar j = 0; j < SSW; j++) begin : g_sel
      assign grp_sel[j] = |lane_en[j*G +: G];
    end

    if (SDW > MDW) begin : g_rep
      assign wdat = {(SDW/MDW){m_dat_w}};
    end else begin : g_trunc
      assign wdat = m_dat_w[SDW-1:0];
    end

    if (HAS_ACK) begin : g_ack
      assign ack_src = s_ack;
    end else begin : g_noack
      assign ack_src = 1'b1;
    end
  endgenerate

  assign s_sel   = hit ? grp_sel : '0;
  assign s_dat_w = hit ? wdat : '0;

  always_comb begin
    rd = '0;
    for (int i = 0; i < SL; i++) begin
      if (lane_en[i]) rd[(i % MB)*8 +: 8] = rd[(i % MB)*8 +: 8] | s_dat_r[i*8 +: 8];
    end
  end

  assign m_dat_r = hit ? rd : '0;
  assign m_ack   = hit & ack_src;
endmodule

module wb_width_port_chk #(
  parameter int AW       = 16,
  parameter int MDW      = 32,
  parameter int SDW      = 64,
  parameter int SSW      = 8,
  parameter int DEC_LSB  = 12,
  parameter int SEL_BASE = 3,
  parameter int BASE     = 3,
  parameter bit HAS_ACK  = 1'b1
) (
  input logic [AW-1:0]               m_adr,
  input logic [MDW/8-1:0]            m_sel,
  input logic                        m_cyc,
  input logic                        m_stb,
  input logic                        m_we,
  input logic [MDW-1:0]              m_dat_r,
  input logic                        m_ack,
  input logic [DEC_LSB-SEL_BASE-1:0] s_adr,
  input logic [SDW-1:0]              s_dat_w,
  input logic [SSW-1:0]              s_sel,
  input logic                        s_cyc,
  input logic                        s_stb,
  input logic                        s_we,
  input logic                        s_ack
);
  logic sel_q;
  assign sel_q = (m_adr[AW-1:DEC_LSB] == (AW-DEC_LSB)'(BASE));

  always_comb begin
    if (!$isunknown(m_adr)) begin
      AST_IDLE_QUIET: assert (sel_q || (s_adr == '0 && s_dat_w == '0 && s_sel == '0 && !s_cyc && !s_stb && !s_we)) else $error("idle outputs not zero"); // R2
      AST_CTRL_FOLLOW: assert (!sel_q || $isunknown({m_cyc, m_stb, m_we}) || (s_cyc == m_cyc && s_stb == m_stb && s_we == m_we)) else $error("control mismatch"); // R3
      AST_ADR_SLICE: assert (!sel_q || s_adr == m_adr[DEC_LSB-1:SEL_BASE]) else $error("address slice"); // R4
      AST_SEL_NEEDS_EN: assert ($isunknown(m_sel) || s_sel == '0 || m_sel != '0) else $error("select without enable"); // R8
      AST_RD_IDLE: assert (sel_q || m_dat_r == '0) else $error("read data while idle"); // R9
      AST_ACK_DECODE: assert (!m_ack || sel_q) else $error("ack while idle"); // R10
      AST_ACK_MISSING: assert (HAS_ACK || !sel_q || m_ack) else $error("ack missing"); // R10
    end
  end
endmodule

bind wb_width_port wb_width_port_chk #(
  .AW(AW), .MDW(MDW), .SDW(SDW), .SSW(SSW), .DEC_LSB(DEC_LSB),
  .SEL_BASE(SEL_BASE), .BASE(BASE), .HAS_ACK(HAS_ACK)
) u_chk (
  .m_adr(m_adr), .m_sel(m_sel), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
  .m_dat_r(m_dat_r), .m_ack(m_ack), .s_adr(s_adr), .s_dat_w(s_dat_w),
  .s_sel(s_sel), .s_cyc(s_cyc), .s_stb(s_stb), .s_we(s_we), .s_ack(s_ack)
);

// File: tb/wb_width_port_tb.sv
module wb_width_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [15:0] m_adr;
  logic [31:0] m_dat_w;
  logic [3:0]  m_sel;
  logic        m_cyc, m_stb, m_we;

  logic [8:0]  w_adr;  logic [63:0] w_dw;  logic [7:0] w_sel;
  logic        w_cyc, w_stb, w_we, w_ack, w_mack;
  logic [63:0] w_rd;   logic [31:0] w_mrd;
  logic [9:0]  e_adr;  logic [31:0] e_dw;  logic [1:0] e_sel;
  logic        e_cyc, e_stb, e_we, e_ack, e_mack;
  logic [31:0] e_rd;   logic [31:0] e_mrd;
  logic [10:0] n_adr;  logic [15:0] n_dw;  logic [0:0] n_sel;
  logic        n_cyc, n_stb, n_we, n_ack, n_mack;
  logic [15:0] n_rd;   logic [31:0] n_mrd;

  wb_width_port #(.SDW(64), .SSW(8), .SEL_BASE(3), .HAS_ACK(1'b1)) u_dut (
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
    .m_dat_r(w_mrd), .m_ack(w_mack), .s_adr(w_adr), .s_dat_w(w_dw), .s_sel(w_sel),
    .s_cyc(w_cyc), .s_stb(w_stb), .s_we(w_we), .s_dat_r(w_rd), .s_ack(w_ack));

  wb_width_port #(.SDW(32), .SSW(2), .SEL_BASE(2), .HAS_ACK(1'b1)) u_dut_eq (
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
    .m_dat_r(e_mrd), .m_ack(e_mack), .s_adr(e_adr), .s_dat_w(e_dw), .s_sel(e_sel),
    .s_cyc(e_cyc), .s_stb(e_stb), .s_we(e_we), .s_dat_r(e_rd), .s_ack(e_ack));

  wb_width_port #(.SDW(16), .SSW(1), .SEL_BASE(1), .HAS_ACK(1'b0)) u_dut_nar (
    .m_adr(m_adr), .m_dat_w(m_dat_w), .m_sel(m_sel), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
    .m_dat_r(n_mrd), .m_ack(n_mack), .s_adr(n_adr), .s_dat_w(n_dw), .s_sel(n_sel),
    .s_cyc(n_cyc), .s_stb(n_stb), .s_we(n_we), .s_dat_r(n_rd), .s_ack(n_ack));

  task automatic chk(string nm, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, nm, act, exp);
    end
  endtask

  task automatic model(string nm, int sdw, int ssw, bit ha, int sb,
                       logic [63:0] a_adr, logic [63:0] a_dw, logic [63:0] a_sel,
                       logic a_cyc, logic a_stb, logic a_we,
                       logic [63:0] srd, logic sack, logic [31:0] a_mrd, logic a_mack);
    int sl = sdw / 8;
    int g  = sl / ssw;
    bit hit = (m_adr[15:12] == 4'd3);
    logic [63:0] x_adr = '0, x_dw = '0, x_sel = '0;
    logic [31:0] x_rd = '0;
    bit en [8];
    for (int i = 0; i < 8; i++) en[i] = 1'b0;
    for (int i = 0; i < sl; i++) begin
      if (sl > 4) en[i] = m_sel[i % 4] && (((m_adr >> 2) % (sl / 4)) == (i / 4));
      else        en[i] = m_sel[i];
    end
    if (hit) begin
      x_adr = 64'(m_adr >> sb) & ((64'd1 << (12 - sb)) - 1);
      for (int i = 0; i < sdw; i++) x_dw[i] = m_dat_w[i % 32];
      for (int j = 0; j < ssw; j++)
        for (int k = 0; k < g; k++) if (en[j*g + k]) x_sel[j] = 1'b1;
      for (int i = 0; i < sl; i++)
        if (en[i]) x_rd[(i % 4)*8 +: 8] = x_rd[(i % 4)*8 +: 8] | srd[i*8 +: 8];
    end
    chk({nm, " cyc"}, "R1 R3", {63'd0, a_cyc}, {63'd0, hit & m_cyc});
    chk({nm, " stb"}, "R2 R3", {63'd0, a_stb}, {63'd0, hit & m_stb});
    chk({nm, " we"},  "R3",    {63'd0, a_we},  {63'd0, hit & m_we});
    chk({nm, " adr"}, "R4",    a_adr, x_adr);
    chk({nm, " wdat"}, "R5",   a_dw, x_dw);
    chk({nm, " sel"}, (sl > 4) ? "R6 R8" : "R7 R8", a_sel, x_sel);
    chk({nm, " rdat"}, "R9",   {32'd0, a_mrd}, {32'd0, x_rd});
    chk({nm, " ack"}, "R10",   {63'd0, a_mack}, {63'd0, hit & (ha ? sack : 1'b1)});
  endtask

  task automatic compare_all;
    model("wide", 64, 8, 1'b1, 3, 64'(w_adr), w_dw, 64'(w_sel), w_cyc, w_stb, w_we, w_rd, w_ack, w_mrd, w_mack);
    model("equal", 32, 2, 1'b1, 2, 64'(e_adr), 64'(e_dw), 64'(e_sel), e_cyc, e_stb, e_we, 64'(e_rd), e_ack, e_mrd, e_mack);
    model("narrow", 16, 1, 1'b0, 1, 64'(n_adr), 64'(n_dw), 64'(n_sel), n_cyc, n_stb, n_we, 64'(n_rd), n_ack, n_mrd, n_mack);
  endtask

  task automatic drive(logic [15:0] a, logic [31:0] d, logic [3:0] s, logic c, logic st, logic we);
    @(posedge clk); #1;
    m_adr = a; m_dat_w = d; m_sel = s; m_cyc = c; m_stb = st; m_we = we;
    w_rd = {$urandom, $urandom}; e_rd = $urandom; n_rd = 16'($urandom);
    w_ack = 1'($urandom); e_ack = 1'($urandom); n_ack = 1'($urandom);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    m_adr = '0; m_dat_w = '0; m_sel = '0; m_cyc = 0; m_stb = 0; m_we = 0;
    w_rd = '0; e_rd = '0; n_rd = '0; w_ack = 0; e_ack = 0; n_ack = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("reset idle", "R2", {w_cyc, w_stb, w_we, w_sel, e_sel, n_sel}, '0);
    compare_all();
    rst = 1'b0;
    // R6 R7 R8: single-byte writes to every master lane and every wide-slave lane group
    for (int grp = 0; grp < 2; grp++)
      for (int b = 0; b < 4; b++)
        drive(16'h3000 | 16'(grp << 2) | 16'h0120, 32'hA1B2C3D4, 4'(1 << b), 1'b1, 1'b1, 1'b1);
    // R1 R2: accesses decoded to a different slave
    drive(16'h2FFC, 32'h12345678, 4'hF, 1'b1, 1'b1, 1'b1);
    drive(16'h4000, 32'h87654321, 4'hF, 1'b1, 1'b1, 1'b0);
    // R10: idle master while selected still acknowledges on a slave without ack
    drive(16'h3000, 32'h0, 4'h0, 1'b0, 1'b0, 1'b0);
    // full-word and half-word reads
    drive(16'h3ABC, 32'h0, 4'hF, 1'b1, 1'b1, 1'b0);
    drive(16'h3004, 32'h0, 4'hC, 1'b1, 1'b1, 1'b0);
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a = 16'($urandom);
      if ($urandom % 2) a[15:12] = 4'd3;
      drive(a, $urandom, 4'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule